// File: doc/BRIEF.md
# Sixteen-Bit Add / Small-Multiply Calculator

This block is a purely combinational arithmetic unit. It takes two 16-bit operands and a one-bit mode input, and it returns one 16-bit result. In add mode the result is the sum of the operands. In multiply mode the result is the first operand multiplied by a two-bit factor taken from the bottom of the second operand.

The multiply path has two steps. Each bit of the factor gates the first operand to form a partial product, and the partial product for the upper factor bit is shifted up by one place. A second adder of the same kind then sums the two partial products. Both adders drop their carry-out, so every result wraps modulo 2^16, and no flag reports a wrap. A bitwise two-to-one selector picks the final result.

The adder structure is a parameter. It can be a plain ripple chain or a carry-select arrangement with a chosen block width.

Top module: `calc_addmul`

## Requirements
- R1: When `mode_mul` is 0, `result_o` equals (`opnd_a` + `opnd_b`) mod 2^16.
- R2: When `mode_mul` is 1, `result_o` equals (`opnd_a` × `opnd_b[1:0]`) mod 2^16.
- R3: In multiply mode, bits [15:2] of `opnd_b` have no effect on `result_o`.
- R4: In multiply mode, a factor of 0 gives a result of 0, and a factor of 1 passes `opnd_a` through unchanged.
- R5: In multiply mode with a factor of 2, the result is `opnd_a` shifted left by one place: a 0 enters bit 0 and the old bit 15 is lost.
- R6: A product that needs more than 16 bits keeps only its low 16 bits. For example, 0xFFFF × 3 gives 0xFFFD and 0x8000 × 2 gives 0x0000.
- R7: Addition wraps with no carry indication. For example, 0xFFFF + 0x0001 gives 0x0000 and 0xFFFF + 0xFFFF gives 0xFFFE.
- R8: The block holds no state. `result_o` reflects the present inputs within one combinational evaluation, and no clock edge is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First operand; also the multiplicand |
| opnd_b | input | 16 | Second operand; bits [1:0] are the multiply factor |
| mode_mul | input | 1 | 0 selects the sum, 1 selects the product |
| result_o | output | 16 | Selected 16-bit result, wrapped modulo 2^16 |

## Verification
The bench aims at the wrap points. A design that keeps a carry would return 0x10000-style values: 0xFFFF + 1 would not read 0, and 0xFFFF × 3 would not read 0xFFFD. A shift that rotates instead of dropping bit 15 would turn 0x8000 × 2 into 0x0001. A design that wrongly reads the upper bits of the second operand in multiply mode would give different results for the same low factor, so the bench repeats one multiply while it scrambles those bits. The bench also checks that factors 0 and 1, if their gating is swapped, show up as a zero or a passed-through operand in the wrong place.

// File: rtl/calc_pkg.sv
package calc_pkg;
   typedef enum logic {
      MODE_ADD = 1'b0,
      MODE_MUL = 1'b1
   } calc_mode_e;

   typedef enum int unsigned {
      ADDER_RIPPLE = 0,
      ADDER_CSEL   = 1
   } adder_kind_e;
endpackage

// File: rtl/calc_ripple.sv
module calc_ripple #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] s,
   output logic         cout
);
   if (W < 1) begin : g_bad_w
      $error("calc_ripple: W must be at least 1");
   end

   logic [W:0] c;
   assign c[0] = cin;

   for (genvar i = 0; i < W; i++) begin : g_fa
      logic p;
      assign p      = a[i] ^ b[i];
      assign s[i]   = p ^ c[i];
      assign c[i+1] = (a[i] & b[i]) | (p & c[i]);
   end

   assign cout = c[W];
endmodule

// File: rtl/calc_adder.sv
module calc_adder
   import calc_pkg::*;
#(
   parameter int unsigned W    = 16,
   parameter adder_kind_e KIND = ADDER_CSEL,
   parameter int unsigned BLK  = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum,
   output logic         cout
);
   localparam int unsigned NBLK = (W + BLK - 1) / BLK;

   if (BLK < 1 || (W % BLK) != 0) begin : g_bad_blk
      $error("calc_adder: BLK must divide W");
   end

   if (KIND == ADDER_RIPPLE) begin : g_ripple
      calc_ripple #(.W(W)) u_chain (
         .a(a), .b(b), .cin(1'b0), .s(sum), .cout(cout)
      );
   end else begin : g_csel
      logic [NBLK:0] cb;
      assign cb[0] = 1'b0;

      for (genvar k = 0; k < NBLK; k++) begin : g_blk
         localparam int unsigned LO = k * BLK;
         logic [BLK-1:0] s0, s1;
         logic           c0, c1;

         calc_ripple #(.W(BLK)) u_c0 (
            .a(a[LO +: BLK]), .b(b[LO +: BLK]), .cin(1'b0), .s(s0), .cout(c0)
         );
         calc_ripple #(.W(BLK)) u_c1 (
            .a(a[LO +: BLK]), .b(b[LO +: BLK]), .cin(1'b1), .s(s1), .cout(c1)
         );

         assign sum[LO +: BLK] = cb[k] ? s1 : s0;
         assign cb[k+1]        = cb[k] ? c1 : c0;
      end

      assign cout = cb[NBLK];
   end

   // R1 R7
   always_comb begin
      if (!$isunknown({a, b})) begin
         wide_sum_chk: assert ({cout, sum} == ((W+1)'(a) + (W+1)'(b)))
            else $error("adder disagrees with arithmetic sum");
      end
   end
endmodule

// File: rtl/calc_gate_mul.sv
module calc_gate_mul #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] d,
   input  logic         bit_i,
   output logic [W-1:0] pp
);
   for (genvar i = 0; i < W; i++) begin : g_and
      assign pp[i] = d[i] & bit_i;
   end

   // R4
   always_comb begin
      if (!$isunknown({d, bit_i})) begin
         gate_zero_chk: assert (bit_i || pp == '0)
            else $error("partial product not cleared by zero bit");
      end
   end
endmodule

// File: rtl/calc_mul2.sv
module calc_mul2
   import calc_pkg::*;
#(
   parameter int unsigned W    = 16,
   parameter adder_kind_e KIND = ADDER_CSEL,
   parameter int unsigned BLK  = 4
) (
   input  logic [W-1:0] a,
   input  logic [1:0]   m,
   output logic [W-1:0] prod
);
   logic [W-1:0] pp0, pp1, a_sh;
   logic         c_drop;

   assign a_sh = {a[W-2:0], 1'b0};

   calc_gate_mul #(.W(W)) u_pp0 (.d(a),    .bit_i(m[0]), .pp(pp0));
   calc_gate_mul #(.W(W)) u_pp1 (.d(a_sh), .bit_i(m[1]), .pp(pp1));

   calc_adder #(.W(W), .KIND(KIND), .BLK(BLK)) u_sum (
      .a(pp0), .b(pp1), .sum(prod), .cout(c_drop)
   );

   // R2 R6
   always_comb begin
      if (!$isunknown({a, m})) begin
         trunc_prod_chk: assert (prod == W'(a * W'(m)))
            else $error("product not the truncated arithmetic product");
         // R6: the dropped carry only appears when the full product overflows
         carry_drop_chk: assert (!c_drop || ((W+2)'(a) * (W+2)'(m)) >= (W+2)'(1 << W))
            else $error("carry raised without overflow");
      end
   end
endmodule

// File: rtl/calc_sel.sv
module calc_sel #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] d0,
   input  logic [W-1:0] d1,
   input  logic         s,
   output logic [W-1:0] y
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign y[i] = (d1[i] & s) | (d0[i] & ~s);
   end
endmodule

// File: rtl/calc_addmul.sv
module calc_addmul
   import calc_pkg::*;
#(
   parameter int unsigned W    = 16,
   parameter adder_kind_e KIND = ADDER_CSEL,
   parameter int unsigned BLK  = 4
) (
   input  logic [15:0] opnd_a,
   input  logic [15:0] opnd_b,
   input  logic        mode_mul,
   output logic [15:0] result_o
);
   if (W != 16) begin : g_bad_width
      $error("calc_addmul: port width is fixed at 16");
   end

   logic [W-1:0] sum_w, prod_w;
   logic         add_c;

   calc_adder #(.W(W), .KIND(KIND), .BLK(BLK)) u_add (
      .a(opnd_a), .b(opnd_b), .sum(sum_w), .cout(add_c)
   );

   calc_mul2 #(.W(W), .KIND(KIND), .BLK(BLK)) u_mul (
      .a(opnd_a), .m(opnd_b[1:0]), .prod(prod_w)
   );

   calc_sel #(.W(W)) u_sel (
      .d0(sum_w), .d1(prod_w), .s(mode_mul), .y(result_o)
   );

   always_comb begin
      if (!$isunknown({opnd_a, opnd_b, mode_mul})) begin
         // R1
         add_path_chk: assert (mode_mul != MODE_ADD || result_o == W'(opnd_a + opnd_b))
            else $error("add mode result wrong");
         // R4
         zero_factor_chk: assert (mode_mul != MODE_MUL || opnd_b[1:0] != 2'd0 || result_o == '0)
            else $error("zero factor gave nonzero product");
         // R5
         shift_factor_chk: assert (mode_mul != MODE_MUL || opnd_b[1:0] != 2'd2 || result_o == {opnd_a[14:0], 1'b0})
            else $error("factor two is not a dropped-bit shift");
         // R7
         add_wrap_chk: assert (!add_c || mode_mul || result_o < opnd_a)
            else $error("wrapped sum not below operand");
      end
   end
endmodule

// File: tb/test_calc_addmul.sv
module test_calc_addmul;
   logic        clk = 1'b0;
   logic [15:0] opnd_a = '0, opnd_b = '0;
   logic        mode_mul = 1'b0;
   logic [15:0] result_o;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   calc_addmul i_calc_addmul (
      .opnd_a(opnd_a), .opnd_b(opnd_b), .mode_mul(mode_mul), .result_o(result_o)
   );

   function automatic logic [15:0] ref_val(logic [15:0] a, logic [15:0] b, logic m);
      logic [17:0] p;
      if (!m) return 16'(a + b);
      p = 18'(a) * 18'(b[1:0]);
      return p[15:0];
   endfunction

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   task automatic check(string req, logic [15:0] got, logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s a=%h b=%h mode=%0d got=%h exp=%h", req, opnd_a, opnd_b, mode_mul, got, exp);
      end
   endtask

   // drive away from the edge, sample 1 ns later with no clock edge between (R8)
   task automatic apply(string req, logic [15:0] a, logic [15:0] b, logic m, logic [15:0] exp);
      @(negedge clk);
      opnd_a = a; opnd_b = b; mode_mul = m;
      #1;
      check(req, result_o, exp);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         finish_up();
      end
   end

   initial begin
      logic [15:0] base;
      void'($urandom(32'd2417));
      #1;
      check("R1 initial zero inputs", result_o, 16'h0000);

      // R1 R7: add and wrap
      apply("R1", 16'h1234, 16'h4321, 1'b0, 16'h5555);
      apply("R7", 16'hFFFF, 16'h0001, 1'b0, 16'h0000);
      apply("R7", 16'hFFFF, 16'hFFFF, 1'b0, 16'hFFFE);
      apply("R7", 16'h8000, 16'h8000, 1'b0, 16'h0000);
      // R4: factor 0 and 1
      apply("R4 zero", 16'hBEEF, 16'h0000, 1'b1, 16'h0000);
      apply("R4 zero", 16'hFFFF, 16'hFFFC, 1'b1, 16'h0000);
      apply("R4 one", 16'hBEEF, 16'h0001, 1'b1, 16'hBEEF);
      // R5: factor 2 shift
      apply("R5", 16'h4321, 16'h0002, 1'b1, 16'h8642);
      apply("R5", 16'hC001, 16'h0002, 1'b1, 16'h8002);
      // R6: truncation
      apply("R6", 16'hFFFF, 16'h0003, 1'b1, 16'hFFFD);
      apply("R6", 16'h8000, 16'h0002, 1'b1, 16'h0000);
      apply("R6", 16'h5555, 16'h0003, 1'b1, 16'hFFFF);
      apply("R2", 16'h0101, 16'h0003, 1'b1, 16'h0303);

      // R3: scramble upper bits of opnd_b, same low factor
      for (int i = 0; i < 64; i++) begin
         base = 16'($urandom);
         apply("R3", base, {14'($urandom), 2'd3}, 1'b1, 16'(base * 16'd3));
      end

      // R8: toggle mode with no clock edge; result follows at once
      @(negedge clk);
      opnd_a = 16'h0F0F; opnd_b = 16'h0102; mode_mul = 1'b0;
      #0.5 check("R8 add", result_o, 16'h1011);
      mode_mul = 1'b1;
      #0.5 check("R8 mul", result_o, 16'h1E1E);

      // R1 R2: constrained random
      for (int i = 0; i < 2000; i++) begin
         logic [15:0] ra, rb;
         logic        rm;
         ra = 16'($urandom);
         rb = 16'($urandom);
         rm = 1'($urandom);
         if (i % 8 == 0) ra = 16'hFFFF;
         if (i % 8 == 1) ra = 16'h8000;
         apply(rm ? "R2 random" : "R1 random", ra, rb, rm, ref_val(ra, rb, rm));
      end

      finish_up();
   end
endmodule